// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block sits beside a four-bank synchronous DRAM controller and watches the command pins on every rising clock edge. It turns each sampled cycle into a named command. It keeps a small state machine for each bank: idle, open, or closing itself after a burst with auto precharge. It reports a one-cycle error vector whenever the command breaks a sequencing rule. It drives nothing back onto the memory bus. Its outputs go to a checker, a trace recorder or an interrupt line.

The burst length used to time auto-precharge bursts is taken from a configuration input. A command that raises any error bit is treated as not having happened. It leaves every bank state, the mode-register quiet window and the self-refresh flag unchanged. All outputs are registered and describe the command sampled at the previous rising edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cke_prev` and `cke` high and `cs_n` low, {ras_n,cas_n,we_n} decodes as 000 mode-register set (code 1), 001 refresh (2), 011 activate (5), 101 read (6), 100 write (7), 110 burst stop (8), 010 precharge (9 single, 10 all) and 111 no-op (0). With `cs_n` high the result is no-op (0).
- R2: For activate, read, write and single-bank precharge, `bank_o` equals `ba` and `bank_mask_o` has only bit `ba` set.
- R3: On a precharge, `a10` high gives code 10 with `bank_mask_o` all ones whatever `ba` is. `a10` low gives code 9.
- R4: Outputs are registered: they describe the command sampled at the previous rising edge. For every command that does not address a bank, `bank_mask_o` and `bank_o` are zero.
- R5: `cke_prev` high with `cke` low gives self-refresh entry (code 3) for the refresh pattern and suspend (code 11) otherwise. `cke_prev` low with `cke` low gives suspend (11). `cke_prev` low with `cke` high gives self-refresh exit (4) if self refresh was entered, else wake (12).
- R6: In the two edges after a mode-register set that raised no error, any command other than no-op sets `err_o[1]`.
- R7: Mode-register set, refresh or self-refresh entry while any bank is not idle sets `err_o[0]`.
- R8: A synchronous `rst` returns every bank to idle and drives `cmd_o`, `bank_o`, `bank_mask_o` and `err_o` to zero.
- R9: A read or write with `a10` high to an open bank holds that bank in auto precharge for the BL-1 edges that follow, then returns it to idle. A read or write on any bank during that window sets `err_o[2]`.
- R10: `burst_len_sel` values 0, 1, 2 and 3 select burst lengths 1, 2, 4 and 8.
- R11: Activate to a bank that is not idle sets `err_o[3]`. Read or write to an idle bank sets `err_o[4]`.
- R12: A command that raises any error bit changes no bank state, starts no quiet window and does not enter self refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_prev | input | 1 | Clock enable as sampled on the previous edge |
| cke | input | 1 | Clock enable at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Address bit 10 (auto precharge / all banks) |
| burst_len_sel | input | 2 | Burst length select |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Target bank |
| bank_mask_o | output | 4 | Banks touched by the command |
| err_o | output | 5 | Rule violation bits, one per rule |

## Verification
The bench sweeps every pin pattern from reset, every bank with both `a10` levels, and every burst length against every probe delay from 1 to 9 edges after an auto-precharge read. An off-by-one in the burst counter would flag a legal read one edge late, or free the bank one edge early. The quiet window after mode-register set is probed on its last edge and on the edge just past it, so a window one cycle short or long is caught. Rejected commands are followed by probes that would disagree if the bank opened, the window started or self refresh was entered, which exposes a design that applies illegal commands anyway.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_REF  = 4'd2,
        CMD_SRE  = 4'd3,
        CMD_SRX  = 4'd4,
        CMD_ACT  = 4'd5,
        CMD_RD   = 4'd6,
        CMD_WR   = 4'd7,
        CMD_BST  = 4'd8,
        CMD_PRE  = 4'd9,
        CMD_PALL = 4'd10,
        CMD_SUSP = 4'd11,
        CMD_WAKE = 4'd12
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE     = 2'd0,
        BK_ACTIVE   = 2'd1,
        BK_AUTOPRE  = 2'd2
    } bank_st_e;

    localparam int ERR_W        = 5;
    localparam int ERR_NOT_IDLE = 0;
    localparam int ERR_MRS_GAP  = 1;
    localparam int ERR_AP_BURST = 2;
    localparam int ERR_ACT_OPEN = 3;
    localparam int ERR_RW_IDLE  = 4;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cke_prev_i,
    input  logic cke_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    input  logic a10_i,
    input  logic in_sref_i,
    output cmd_e cmd_o
);

    cmd_e pin_cmd;

    always_comb begin
        unique case ({ras_n_i, cas_n_i, we_n_i})
            3'b000:  pin_cmd = CMD_MRS;
            3'b001:  pin_cmd = CMD_REF;
            3'b011:  pin_cmd = CMD_ACT;
            3'b101:  pin_cmd = CMD_RD;
            3'b100:  pin_cmd = CMD_WR;
            3'b110:  pin_cmd = CMD_BST;
            3'b010:  pin_cmd = a10_i ? CMD_PALL : CMD_PRE;
            default: pin_cmd = CMD_NOP;
        endcase
    end

    always_comb begin
        if (!cke_prev_i) begin
            if (cke_i) cmd_o = in_sref_i ? CMD_SRX : CMD_WAKE;
            else       cmd_o = CMD_SUSP;
        end else if (cs_n_i) begin
            cmd_o = cke_i ? CMD_NOP : CMD_SUSP;
        end else if (!cke_i) begin
            cmd_o = (pin_cmd == CMD_REF) ? CMD_SRE : CMD_SUSP;
        end else begin
            cmd_o = pin_cmd;
        end
    end

endmodule

// File: rtl/sdram_bank_slice.sv
module sdram_bank_slice
    import sdram_mon_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       open_i,
    input  logic       close_i,
    input  logic       rw_ap_i,
    input  logic [1:0] bl_sel_i,
    output bank_st_e   state_o
);

    typedef struct packed {
        bank_st_e          st;
        logic [CNT_W-1:0]  cnt;
    } slice_t;

    slice_t q, d;

    always_comb begin
        d = q;
        if (q.st == BK_AUTOPRE) begin
            if (q.cnt == '0) d.st = BK_IDLE;
            else             d.cnt = q.cnt - 1'b1;
        end
        if (close_i) begin
            d.st  = BK_IDLE;
            d.cnt = '0;
        end else if (open_i) begin
            d.st = BK_ACTIVE;
        end else if (rw_ap_i) begin
            if (bl_sel_i == 2'd0) begin
                d.st = BK_IDLE;
            end else begin
                d.st  = BK_AUTOPRE;
                d.cnt = CNT_W'((1 << bl_sel_i) - 2);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= BK_IDLE;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int MRS_GAP   = 2,
    parameter int CNT_W     = 3,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cke_prev,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [BA_W-1:0]       ba,
    input  logic                  a10,
    input  logic [1:0]            burst_len_sel,
    output logic [3:0]            cmd_o,
    output logic [BA_W-1:0]       bank_o,
    output logic [NUM_BANKS-1:0]  bank_mask_o,
    output logic [ERR_W-1:0]      err_o
);

    localparam int GAP_W = $clog2(MRS_GAP + 1);

    typedef struct packed {
        logic [3:0]           cmd;
        logic [BA_W-1:0]      bank;
        logic [NUM_BANKS-1:0] mask;
        logic [ERR_W-1:0]     err;
        logic [GAP_W-1:0]     mrs_cnt;
        logic                 sref;
    } mon_t;

    mon_t q, d;

    cmd_e                 dec_cmd;
    bank_st_e             bank_st [NUM_BANKS];
    logic [NUM_BANKS-1:0] open_v, close_v, rw_ap_v;

    sdram_cmd_decode u_decode (
        .cke_prev_i (cke_prev),
        .cke_i      (cke),
        .cs_n_i     (cs_n),
        .ras_n_i    (ras_n),
        .cas_n_i    (cas_n),
        .we_n_i     (we_n),
        .a10_i      (a10),
        .in_sref_i  (q.sref),
        .cmd_o      (dec_cmd)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdram_bank_slice #(.CNT_W(CNT_W)) u_slice (
            .clk      (clk),
            .rst      (rst),
            .open_i   (open_v[g]),
            .close_i  (close_v[g]),
            .rw_ap_i  (rw_ap_v[g]),
            .bl_sel_i (burst_len_sel),
            .state_o  (bank_st[g])
        );
    end

    logic     any_open, any_ap, is_rw, bank_cmd, legal;
    bank_st_e tgt_st;
    logic [ERR_W-1:0] err;

    always_comb begin
        any_open = 1'b0;
        any_ap   = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_st[i] != BK_IDLE)    any_open = 1'b1;
            if (bank_st[i] == BK_AUTOPRE) any_ap   = 1'b1;
        end
        tgt_st   = bank_st[ba];
        is_rw    = (dec_cmd == CMD_RD) || (dec_cmd == CMD_WR);
        bank_cmd = is_rw || (dec_cmd == CMD_ACT) || (dec_cmd == CMD_PRE);

        err = '0;
        if ((dec_cmd == CMD_MRS || dec_cmd == CMD_REF || dec_cmd == CMD_SRE) && any_open)
            err[ERR_NOT_IDLE] = 1'b1;
        if (q.mrs_cnt != '0 && dec_cmd != CMD_NOP)
            err[ERR_MRS_GAP] = 1'b1;
        if (is_rw && any_ap)
            err[ERR_AP_BURST] = 1'b1;
        if (dec_cmd == CMD_ACT && tgt_st != BK_IDLE)
            err[ERR_ACT_OPEN] = 1'b1;
        if (is_rw && tgt_st == BK_IDLE)
            err[ERR_RW_IDLE] = 1'b1;
        legal = (err == '0);

        for (int i = 0; i < NUM_BANKS; i++) begin
            open_v[i]  = legal && dec_cmd == CMD_ACT && ba == BA_W'(i);
            rw_ap_v[i] = legal && is_rw && a10 && ba == BA_W'(i);
            close_v[i] = legal && ((dec_cmd == CMD_PRE && ba == BA_W'(i))
                                   || dec_cmd == CMD_PALL);
        end

        d      = q;
        d.cmd  = dec_cmd;
        d.err  = err;
        d.bank = bank_cmd ? ba : '0;
        if (bank_cmd)                d.mask = NUM_BANKS'(1) << ba;
        else if (dec_cmd == CMD_PALL) d.mask = '1;
        else                         d.mask = '0;

        if (legal && dec_cmd == CMD_MRS) d.mrs_cnt = GAP_W'(MRS_GAP);
        else if (q.mrs_cnt != '0)        d.mrs_cnt = q.mrs_cnt - 1'b1;

        if (legal && dec_cmd == CMD_SRE) d.sref = 1'b1;
        else if (dec_cmd == CMD_SRX)     d.sref = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign cmd_o       = q.cmd;
    assign bank_o      = q.bank;
    assign bank_mask_o = q.mask;
    assign err_o       = q.err;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [3:0]           cmd_o,
    input logic [BA_W-1:0]      bank_o,
    input logic [NUM_BANKS-1:0] bank_mask_o,
    input logic [ERR_W-1:0]     err_o
);

    logic bank_kind;
    assign bank_kind = cmd_o == CMD_ACT || cmd_o == CMD_RD ||
                       cmd_o == CMD_WR  || cmd_o == CMD_PRE;

    a_r2_mask_matches_bank: assert property (@(posedge clk) disable iff (rst)
        bank_kind |-> ($countones(bank_mask_o) == 1 && bank_mask_o[bank_o]));

    a_r3_all_bank_mask: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_PALL |-> bank_mask_o == '1);

    a_r4_no_bank_no_mask: assert property (@(posedge clk) disable iff (rst)
        (!bank_kind && cmd_o != CMD_PALL) |-> (bank_mask_o == '0 && bank_o == '0));

    a_r6_quiet_after_mrs: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_MRS && err_o == '0) |=> (cmd_o == CMD_NOP || err_o[ERR_MRS_GAP]));

    a_r8_clear_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (cmd_o == CMD_NOP && err_o == '0 && bank_mask_o == '0));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_o       (cmd_o),
    .bank_o      (bank_o),
    .bank_mask_o (bank_mask_o),
    .err_o       (err_o)
);

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke_prev = 1'b1, cke = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic [1:0] burst_len_sel = 2'd0;
    logic [3:0] cmd_o;
    logic [1:0] bank_o;
    logic [3:0] bank_mask_o;
    logic [4:0] err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sdram_cmd_monitor u_sdram_cmd_monitor (
        .clk(clk), .rst(rst), .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .burst_len_sel(burst_len_sel), .cmd_o(cmd_o), .bank_o(bank_o),
        .bank_mask_o(bank_mask_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // Drive one cycle: pins set at the falling edge, outputs sampled 5 ns after the rising edge.
    task automatic step(input logic cp, input logic c, input logic cs,
                        input logic [2:0] rcw, input logic [1:0] b, input logic ap);
        @(negedge clk);
        cke_prev = cp; cke = c; cs_n = cs;
        {ras_n, cas_n, we_n} = rcw;
        ba = b; a10 = ap;
        @(posedge clk);
        #5;
    endtask

    task automatic nop();
        step(1'b1, 1'b1, 1'b1, 3'b111, 2'd0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        nop();
        rst = 1'b0;
    endtask

    function automatic int exp_cmd(input logic [2:0] rcw, input logic ap);
        case (rcw)
            3'b000: return 1;
            3'b001: return 2;
            3'b011: return 5;
            3'b101: return 6;
            3'b100: return 7;
            3'b110: return 8;
            3'b010: return ap ? 10 : 9;
            default: return 0;
        endcase
    endfunction

    localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_ACT = 3'b011,
                           P_RD  = 3'b101, P_WR  = 3'b100, P_PRE = 3'b010;

    initial begin
        // R8: reset state
        do_reset();
        chk("R8 cmd", cmd_o, 0);
        chk("R8 err", err_o, 0);
        chk("R8 mask", bank_mask_o, 0);
        chk("R8 bank", bank_o, 0);

        // R1/R4: every pin pattern, fresh from reset
        for (int cs = 0; cs < 2; cs++) begin
            for (int p = 0; p < 8; p++) begin
                for (int ap = 0; ap < 2; ap++) begin
                    int ec, ee;
                    do_reset();
                    step(1'b1, 1'b1, cs[0], p[2:0], 2'd2, ap[0]);
                    ec = cs ? 0 : exp_cmd(p[2:0], ap[0]);
                    ee = (ec == 6 || ec == 7) ? 16 : 0;
                    chk("R1 decode", cmd_o, ec);
                    chk("R11 rw idle", err_o, ee);
                    if (ec == 0 || ec == 1 || ec == 2 || ec == 8)
                        chk("R4 mask zero", bank_mask_o, 0);
                end
            end
        end

        // R2/R3: bank selection and all-bank precharge
        for (int b = 0; b < 4; b++) begin
            do_reset();
            step(1'b1, 1'b1, 1'b0, P_ACT, b[1:0], 1'b0);
            chk("R2 act bank", bank_o, b);
            chk("R2 act mask", bank_mask_o, 1 << b);
            step(1'b1, 1'b1, 1'b0, P_PRE, b[1:0], 1'b0);
            chk("R3 single pre", cmd_o, 9);
            chk("R2 pre mask", bank_mask_o, 1 << b);
            step(1'b1, 1'b1, 1'b0, P_PRE, b[1:0], 1'b1);
            chk("R3 all pre", cmd_o, 10);
            chk("R3 all mask", bank_mask_o, 15);
        end

        // R3: all-bank precharge closes every bank
        do_reset();
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd1, 1'b0);
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd3, 1'b0);
        step(1'b1, 1'b1, 1'b0, P_PRE, 2'd0, 1'b1);
        step(1'b1, 1'b1, 1'b0, P_REF, 2'd0, 1'b0);
        chk("R3 pall closes", err_o, 0);

        // R5: self refresh entry, suspend, exit; wake without entry
        do_reset();
        step(1'b1, 1'b0, 1'b0, P_REF, 2'd0, 1'b0);
        chk("R5 sre", cmd_o, 3);
        step(1'b0, 1'b0, 1'b0, P_ACT, 2'd0, 1'b0);
        chk("R5 suspend", cmd_o, 11);
        step(1'b0, 1'b1, 1'b1, 3'b111, 2'd0, 1'b0);
        chk("R5 srx", cmd_o, 4);
        step(1'b1, 1'b0, 1'b0, P_ACT, 2'd0, 1'b0);
        chk("R5 power down entry", cmd_o, 11);
        step(1'b0, 1'b1, 1'b1, 3'b111, 2'd0, 1'b0);
        chk("R5 wake", cmd_o, 12);

        // R6: quiet window after mode-register set
        do_reset();
        step(1'b1, 1'b1, 1'b0, P_MRS, 2'd0, 1'b0);
        chk("R6 mrs legal", err_o, 0);
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd0, 1'b0);
        chk("R6 first edge", err_o, 2);
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd0, 1'b0);
        chk("R6 second edge", err_o, 2);
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd0, 1'b0);
        chk("R6 window over", err_o, 0);
        do_reset();
        step(1'b1, 1'b1, 1'b0, P_MRS, 2'd0, 1'b0);
        nop();
        nop();
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd1, 1'b0);
        chk("R6 nops allowed", err_o, 0);

        // R7/R12: not-idle rules; rejected commands take no effect
        do_reset();
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd2, 1'b0);
        step(1'b1, 1'b1, 1'b0, P_MRS, 2'd0, 1'b0);
        chk("R7 mrs open", err_o, 1);
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd1, 1'b0);
        chk("R12 no window", err_o, 0);
        step(1'b1, 1'b1, 1'b0, P_REF, 2'd0, 1'b0);
        chk("R7 ref open", err_o, 1);
        step(1'b1, 1'b0, 1'b0, P_REF, 2'd0, 1'b0);
        chk("R7 sre open", err_o, 1);
        step(1'b0, 1'b1, 1'b1, 3'b111, 2'd0, 1'b0);
        chk("R12 no sref", cmd_o, 12);

        // R11/R12: activate on open bank, read on idle bank
        do_reset();
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd0, 1'b0);
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd0, 1'b0);
        chk("R11 act open", err_o, 8);
        step(1'b1, 1'b1, 1'b0, P_WR, 2'd3, 1'b0);
        chk("R11 wr idle", err_o, 16);
        step(1'b1, 1'b1, 1'b0, P_RD, 2'd3, 1'b0);
        chk("R12 wr rejected", err_o, 16);
        step(1'b1, 1'b1, 1'b0, P_RD, 2'd0, 1'b0);
        chk("R11 rd open ok", err_o, 0);

        // R9/R10: every burst length against every probe delay
        for (int s = 0; s < 4; s++) begin
            for (int k = 1; k < 10; k++) begin
                for (int probe = 0; probe < 2; probe++) begin
                    int bl;
                    bl = 1 << s;
                    burst_len_sel = s[1:0];
                    do_reset();
                    step(1'b1, 1'b1, 1'b0, P_ACT, 2'd0, 1'b0);
                    step(1'b1, 1'b1, 1'b0, P_ACT, 2'd1, 1'b0);
                    step(1'b1, 1'b1, 1'b0, P_RD, 2'd0, 1'b1);
                    for (int n = 1; n < k; n++) nop();
                    if (probe == 0) begin
                        step(1'b1, 1'b1, 1'b0, P_RD, 2'd1, 1'b0);
                        chk("R9 other bank", err_o, (k < bl) ? 4 : 0);
                    end else begin
                        step(1'b1, 1'b1, 1'b0, P_RD, 2'd0, 1'b0);
                        chk("R10 bank back idle", err_o, (k < bl) ? 4 : 16);
                    end
                end
            end
        end

        // R9: write with auto precharge, same bank
        burst_len_sel = 2'd1;
        do_reset();
        step(1'b1, 1'b1, 1'b0, P_ACT, 2'd2, 1'b0);
        step(1'b1, 1'b1, 1'b0, P_WR, 2'd2, 1'b1);
        step(1'b1, 1'b1, 1'b0, P_WR, 2'd2, 1'b0);
        chk("R9 same bank wr", err_o, 4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule